// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Unit

This unit computes the four floating-point condition bits for two operations on 80-bit extended-precision values. An 80-bit value has a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is the explicit integer bit. In compare mode, the unit orders the top-of-stack value against a second operand. In classify mode, it reports the kind of value held at the top of the stack, and that report includes an empty slot.

One request is issued with a single-cycle `op_valid` strobe. The result is registered. Exactly one cycle later it appears on `res_cc` together with a `res_done` pulse. The condition bits stay unchanged until the next request. An unordered compare also raises `res_invalid` for that same cycle only. The unit does not round, keep the stack, access memory or trap on exceptions.

Magnitude ordering is built from a chunked comparator. Its chunk width is a parameter. When the chunk width covers the whole magnitude, a single wide comparator is used instead.

Top module: `fpcc_unit`

## Requirements
- R1: When `op_valid` is high at a rising clock edge, `res_done` is high for exactly the following cycle and `res_cc` holds that request's result. Without a request, `res_done` is low.
- R2: In compare mode (`op_sel`=0), a top value greater than the operand gives `res_cc`={C3,C2,C1,C0}=4'b0000. C1 is always 0 in compare mode.
- R3: In compare mode, a top value less than the operand gives `res_cc`=4'b0001.
- R4: In compare mode, equal values give `res_cc`=4'b1000, and a positive zero compared with a negative zero counts as equal.
- R5: A compare is unordered when either value is a NaN, either value is unsupported, or the top slot is flagged empty. An unordered compare gives `res_cc`=4'b1101 and sets `res_invalid` high only in the `res_done` cycle. A classify request never sets `res_invalid`.
- R6: In classify mode (`op_sel`=1), {C3,C2,C0} encodes the class as follows: 000 unsupported, 001 NaN, 010 normal, 011 infinity, 100 zero, 101 empty, 110 denormal. The classes are decided by the exponent (E), the integer bit (J) and the fraction (F):
  - Unsupported: E is nonzero and J=0.
  - Infinity: E is all ones, J=1 and F=0.
  - NaN: E is all ones, J=1 and F is nonzero.
  - Zero: E=0, J=0 and F=0.
  - Denormal: E=0 and {J,F} is nonzero.
  - Normal: every other value with J=1.
- R7: In classify mode, C1 (`res_cc[1]`) equals the sign bit of the top value. It is 0 for positive and 1 for negative.
- R8: When `top_empty` is high, classify reports the empty class whatever the value bits hold.
- R9: During and right after reset, `res_done`=0, `res_invalid`=0 and `res_cc`=4'b0000.
- R10: `res_cc` keeps its last value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_sel | input | 1 | 0 selects compare, 1 selects classify |
| top_empty | input | 1 | The top-of-stack slot holds no value |
| top_val | input | 1+EXP_W+MAN_W | Top-of-stack value {sign, exponent, significand} |
| opnd_val | input | 1+EXP_W+MAN_W | Second operand for compare |
| res_done | output | 1 | Result valid, one cycle after the request |
| res_cc | output | 4 | Condition bits {C3,C2,C1,C0} |
| res_invalid | output | 1 | Unordered compare flag, pulses with `res_done` |

## Verification
The bench builds the unit with EXP_W=15, MAN_W=64 and CHUNK_W=16. The 79-bit magnitude is therefore split into five padded chunks, so the chunk-priority reduction is exercised instead of the single wide comparator. Pairs that differ only in the lowest significand bit, or only in the exponent, reach the last chunk and the first chunk of that reduction. Signed pairs, zeros of both signs, denormals and infinities check the sign-magnitude ordering around it.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

   // {C3,C2,C0} codes for the two operations
   typedef enum logic [2:0] {
      CLS_UNSUP = 3'b000,
      CLS_NAN   = 3'b001,
      CLS_NORM  = 3'b010,
      CLS_INF   = 3'b011,
      CLS_ZERO  = 3'b100,
      CLS_EMPTY = 3'b101,
      CLS_DEN   = 3'b110
   } fp_class_e;

   localparam logic [2:0] ORD_GT = 3'b000;
   localparam logic [2:0] ORD_LT = 3'b001;
   localparam logic [2:0] ORD_EQ = 3'b100;
   localparam logic [2:0] ORD_UN = 3'b111;

   typedef struct packed {
      logic nan;
      logic inf;
      logic zero;
      logic den;
      logic unsup;
      logic norm;
      logic sign;
   } fp_kind_t;

   // Place the three-bit code and C1 into {C3,C2,C1,C0}
   function automatic logic [3:0] pack_cc(input logic [2:0] code, input logic c1);
      return {code[2], code[1], c1, code[0]};
   endfunction

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
   import fpcc_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64
) (
   input  logic [EXP_W+MAN_W:0] val,
   output fp_kind_t             kind
);

   localparam int VAL_W = 1 + EXP_W + MAN_W;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fpcc_classify: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("fpcc_classify: MAN_W must be at least 2");
   end

   logic [EXP_W-1:0] exp_f;
   logic             int_bit;
   logic [MAN_W-2:0] frac_f;
   logic             exp_max, exp_zero, frac_nz;

   assign exp_f    = val[VAL_W-2:MAN_W];
   assign int_bit  = val[MAN_W-1];
   assign frac_f   = val[MAN_W-2:0];
   assign exp_max  = &exp_f;
   assign exp_zero = ~|exp_f;
   assign frac_nz  = |frac_f;

   always_comb begin
      kind.sign  = val[VAL_W-1];
      kind.unsup = !exp_zero && !int_bit;
      kind.zero  = exp_zero && !int_bit && !frac_nz;
      kind.den   = exp_zero && (int_bit || frac_nz);
      kind.inf   = exp_max && int_bit && !frac_nz;
      kind.nan   = exp_max && int_bit && frac_nz;
      kind.norm  = !exp_zero && !exp_max && int_bit;
   end

endmodule

// File: rtl/fpcc_magcmp.sv
module fpcc_magcmp #(
   parameter int IN_W    = 79,
   parameter int CHUNK_W = 16
) (
   input  logic [IN_W-1:0] a,
   input  logic [IN_W-1:0] b,
   output logic            gt,
   output logic            lt
);

   if (CHUNK_W < 1) begin : g_bad_chunk
      $error("fpcc_magcmp: CHUNK_W must be positive");
   end

   if (CHUNK_W >= IN_W) begin : g_wide
      assign gt = a > b;
      assign lt = a < b;
   end else begin : g_chunked
      localparam int NCH   = (IN_W + CHUNK_W - 1) / CHUNK_W;
      localparam int PAD_W = NCH * CHUNK_W;

      logic [PAD_W-1:0] ap, bp;
      logic [NCH-1:0]   cgt, clt;

      // pad at the low end so chunk order matches significance
      always_comb begin
         ap = '0;
         bp = '0;
         ap[PAD_W-1 -: IN_W] = a;
         bp[PAD_W-1 -: IN_W] = b;
      end

      for (genvar i = 0; i < NCH; i++) begin : g_chunk
         assign cgt[i] = ap[i*CHUNK_W +: CHUNK_W] > bp[i*CHUNK_W +: CHUNK_W];
         assign clt[i] = ap[i*CHUNK_W +: CHUNK_W] < bp[i*CHUNK_W +: CHUNK_W];
      end

      // the most significant differing chunk decides
      always_comb begin
         logic decided;
         decided = 1'b0;
         gt      = 1'b0;
         lt      = 1'b0;
         for (int i = NCH - 1; i >= 0; i--) begin
            if (!decided && (cgt[i] || clt[i])) begin
               gt      = cgt[i];
               lt      = clt[i];
               decided = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
   import fpcc_pkg::*;
#(
   parameter int EXP_W   = 15,
   parameter int MAN_W   = 64,
   parameter int CHUNK_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic                 op_sel,
   input  logic                 top_empty,
   input  logic [EXP_W+MAN_W:0] top_val,
   input  logic [EXP_W+MAN_W:0] opnd_val,
   output logic                 res_done,
   output logic [3:0]           res_cc,
   output logic                 res_invalid
);

   localparam int VAL_W = 1 + EXP_W + MAN_W;
   localparam int MAG_W = VAL_W - 1;

   fp_kind_t  ka, kb;
   logic      mag_gt, mag_lt;
   logic      unord;
   logic [2:0] ord_code;
   fp_class_e cls_code;
   logic [3:0] cc_next;

   fpcc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_top (
      .val  (top_val),
      .kind (ka)
   );

   fpcc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_opnd (
      .val  (opnd_val),
      .kind (kb)
   );

   fpcc_magcmp #(.IN_W(MAG_W), .CHUNK_W(CHUNK_W)) u_mag (
      .a  (top_val[MAG_W-1:0]),
      .b  (opnd_val[MAG_W-1:0]),
      .gt (mag_gt),
      .lt (mag_lt)
   );

   assign unord = top_empty || ka.nan || ka.unsup || kb.nan || kb.unsup;

   always_comb begin
      if (unord)                       ord_code = ORD_UN;
      else if (ka.zero && kb.zero)     ord_code = ORD_EQ;
      else if (ka.sign != kb.sign)     ord_code = ka.sign ? ORD_LT : ORD_GT;
      else if (!mag_gt && !mag_lt)     ord_code = ORD_EQ;
      else if (mag_gt ^ ka.sign)       ord_code = ORD_GT;
      else                             ord_code = ORD_LT;
   end

   always_comb begin
      if (top_empty)     cls_code = CLS_EMPTY;
      else if (ka.nan)   cls_code = CLS_NAN;
      else if (ka.inf)   cls_code = CLS_INF;
      else if (ka.zero)  cls_code = CLS_ZERO;
      else if (ka.den)   cls_code = CLS_DEN;
      else if (ka.unsup) cls_code = CLS_UNSUP;
      else               cls_code = CLS_NORM;
   end

   assign cc_next = op_sel ? pack_cc(cls_code, ka.sign) : pack_cc(ord_code, 1'b0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_done    <= 1'b0;
         res_cc      <= 4'b0000;
         res_invalid <= 1'b0;
      end else begin
         res_done    <= op_valid;
         res_invalid <= op_valid && !op_sel && unord;
         if (op_valid) res_cc <= cc_next;
      end
   end

   // checks
   assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_done);
   assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_done);
   assert_cmp_c1_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !$past(op_sel)) |-> !res_cc[1]);
   assert_mag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mag_gt && mag_lt));
   assert_inv_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_invalid |-> (res_done && res_cc[3] && res_cc[2] && res_cc[0] && !res_cc[1]));
   assert_cls_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && $past(op_sel)) |-> !(res_cc[3] && res_cc[2] && res_cc[0]));
   assert_top_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ka.nan, ka.inf, ka.zero, ka.den, ka.unsup, ka.norm}) == 1);
   assert_opnd_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({kb.nan, kb.inf, kb.zero, kb.den, kb.unsup, kb.norm, kb.sign}) >= 1);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_valid) |-> $stable(res_cc));

endmodule

// File: tb/fpcc_unit_bench.sv
`timescale 1ns/1ps
module fpcc_unit_bench;

   localparam int EXP_W = 15;
   localparam int MAN_W = 64;
   localparam int VW    = 1 + EXP_W + MAN_W;
   localparam int REC_W = 4 + 1 + 1 + VW + VW + 4 + 1;
   localparam int N_VEC = 31;
   localparam int WATCHDOG = 20000;

   function automatic logic [VW-1:0] mk(input logic s, input logic [EXP_W-1:0] e,
                                        input logic [MAN_W-1:0] m);
      return {s, e, m};
   endfunction

   localparam logic [MAN_W-1:0] J1 = {1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [VW-1:0] ONE   = mk(1'b0, 15'h3FFF, J1);
   localparam logic [VW-1:0] ONEL  = mk(1'b0, 15'h3FFF, J1 | 64'd1);
   localparam logic [VW-1:0] NONE  = mk(1'b1, 15'h3FFF, J1);
   localparam logic [VW-1:0] TWO   = mk(1'b0, 15'h4000, J1);
   localparam logic [VW-1:0] NTWO  = mk(1'b1, 15'h4000, J1);
   localparam logic [VW-1:0] PZ    = mk(1'b0, 15'h0000, 64'd0);
   localparam logic [VW-1:0] NZ    = mk(1'b1, 15'h0000, 64'd0);
   localparam logic [VW-1:0] PINF  = mk(1'b0, 15'h7FFF, J1);
   localparam logic [VW-1:0] NINF  = mk(1'b1, 15'h7FFF, J1);
   localparam logic [VW-1:0] QNAN  = mk(1'b0, 15'h7FFF, 64'hC000_0000_0000_0000);
   localparam logic [VW-1:0] UNSP  = mk(1'b0, 15'h3FFF, 64'h4000_0000_0000_0000);
   localparam logic [VW-1:0] DEN   = mk(1'b0, 15'h0000, 64'd1);
   localparam logic [VW-1:0] NDEN  = mk(1'b1, 15'h0000, 64'd1);

   // {req, sel, empty, top, opnd, cc {C3,C2,C1,C0}, invalid}
   localparam logic [REC_W-1:0] VECS [N_VEC] = '{
      {4'd2, 1'b0, 1'b0, ONE,  PZ,   4'b0000, 1'b0},  // R2
      {4'd2, 1'b0, 1'b0, ONE,  NONE, 4'b0000, 1'b0},  // R2
      {4'd2, 1'b0, 1'b0, NONE, NTWO, 4'b0000, 1'b0},  // R2
      {4'd2, 1'b0, 1'b0, PINF, TWO,  4'b0000, 1'b0},  // R2
      {4'd2, 1'b0, 1'b0, DEN,  PZ,   4'b0000, 1'b0},  // R2
      {4'd2, 1'b0, 1'b0, TWO,  ONE,  4'b0000, 1'b0},  // R2
      {4'd3, 1'b0, 1'b0, PZ,   ONE,  4'b0001, 1'b0},  // R3
      {4'd3, 1'b0, 1'b0, NONE, ONE,  4'b0001, 1'b0},  // R3
      {4'd3, 1'b0, 1'b0, NTWO, NONE, 4'b0001, 1'b0},  // R3
      {4'd3, 1'b0, 1'b0, ONE,  ONEL, 4'b0001, 1'b0},  // R3
      {4'd3, 1'b0, 1'b0, NZ,   DEN,  4'b0001, 1'b0},  // R3
      {4'd4, 1'b0, 1'b0, ONE,  ONE,  4'b1000, 1'b0},  // R4
      {4'd4, 1'b0, 1'b0, PZ,   NZ,   4'b1000, 1'b0},  // R4
      {4'd4, 1'b0, 1'b0, NINF, NINF, 4'b1000, 1'b0},  // R4
      {4'd5, 1'b0, 1'b0, QNAN, ONE,  4'b1101, 1'b1},  // R5
      {4'd5, 1'b0, 1'b0, ONE,  QNAN, 4'b1101, 1'b1},  // R5
      {4'd5, 1'b0, 1'b0, UNSP, ONE,  4'b1101, 1'b1},  // R5
      {4'd5, 1'b0, 1'b1, ONE,  ONE,  4'b1101, 1'b1},  // R5
      {4'd6, 1'b1, 1'b0, ONE,  PZ,   4'b0100, 1'b0},  // R6
      {4'd6, 1'b1, 1'b0, PZ,   ONE,  4'b1000, 1'b0},  // R6
      {4'd6, 1'b1, 1'b0, PINF, PZ,   4'b0101, 1'b0},  // R6
      {4'd6, 1'b1, 1'b0, QNAN, PZ,   4'b0001, 1'b0},  // R6
      {4'd6, 1'b1, 1'b0, UNSP, PZ,   4'b0000, 1'b0},  // R6
      {4'd6, 1'b1, 1'b0, DEN,  PZ,   4'b1100, 1'b0},  // R6
      {4'd7, 1'b1, 1'b0, NONE, PZ,   4'b0110, 1'b0},  // R7
      {4'd7, 1'b1, 1'b0, NZ,   PZ,   4'b1010, 1'b0},  // R7
      {4'd7, 1'b1, 1'b0, NINF, PZ,   4'b0111, 1'b0},  // R7
      {4'd7, 1'b1, 1'b0, NDEN, PZ,   4'b1110, 1'b0},  // R7
      {4'd8, 1'b1, 1'b1, ONE,  PZ,   4'b1001, 1'b0},  // R8
      {4'd8, 1'b1, 1'b1, QNAN, PZ,   4'b1001, 1'b0},  // R8
      {4'd8, 1'b1, 1'b1, NONE, PZ,   4'b1011, 1'b0}   // R8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic          op_sel = 1'b0;
   logic          top_empty = 1'b0;
   logic [VW-1:0] top_val = '0;
   logic [VW-1:0] opnd_val = '0;
   logic          res_done;
   logic [3:0]    res_cc;
   logic          res_invalid;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   fpcc_unit #(.EXP_W(EXP_W), .MAN_W(MAN_W), .CHUNK_W(16)) u_fpcc_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_sel      (op_sel),
      .top_empty   (top_empty),
      .top_val     (top_val),
      .opnd_val    (opnd_val),
      .res_done    (res_done),
      .res_cc      (res_cc),
      .res_invalid (res_invalid)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic issue(input logic sel, input logic emp,
                        input logic [VW-1:0] t, input logic [VW-1:0] o);
      op_valid  = 1'b1;
      op_sel    = sel;
      top_empty = emp;
      top_val   = t;
      opnd_val  = o;
   endtask

   initial begin
      logic [3:0] held;
      repeat (3) @(negedge clk);
      // R9: reset state while in reset
      check("R9 done in reset", {3'b0, res_done}, 4'b0);
      check("R9 cc in reset", res_cc, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 done after reset", {3'b0, res_done}, 4'b0);
      check("R9 invalid after reset", {3'b0, res_invalid}, 4'b0);
      check("R9 cc after reset", res_cc, 4'b0000);

      // vector table
      for (int i = 0; i < N_VEC; i++) begin
         logic [REC_W-1:0] r;
         string tag;
         r = VECS[i];
         issue(r[REC_W-5], r[REC_W-6], r[REC_W-7 -: VW], r[4+1+VW-1 -: VW]);
         @(negedge clk);
         op_valid = 1'b0;
         tag = $sformatf("R%0d vec%0d", r[REC_W-1 -: 4], i);
         check({tag, " cc"}, res_cc, r[4:1]);
         check({tag, " invalid"}, {3'b0, res_invalid}, {3'b0, r[0]});
         check({"R1 ", tag, " done"}, {3'b0, res_done}, 4'b0001);
      end

      // R10 and R1: idle cycles hold the result, no done, no invalid (R5 single pulse)
      issue(1'b0, 1'b0, QNAN, ONE);
      @(negedge clk);
      op_valid = 1'b0;
      held = res_cc;
      check("R5 setup cc", held, 4'b1101);
      for (int k = 0; k < 3; k++) begin
         op_sel   = 1'b1;
         top_val  = PINF;
         opnd_val = NTWO;
         @(negedge clk);
         check("R10 hold cc", res_cc, held);
         check("R1 idle done", {3'b0, res_done}, 4'b0);
         check("R5 invalid one cycle", {3'b0, res_invalid}, 4'b0);
      end

      // R1: back-to-back requests
      issue(1'b0, 1'b0, TWO, ONE);
      @(negedge clk);
      check("R1 b2b first cc", res_cc, 4'b0000);
      issue(1'b0, 1'b0, ONE, TWO);
      @(negedge clk);
      check("R1 b2b second cc", res_cc, 4'b0001);
      check("R1 b2b second done", {3'b0, res_done}, 4'b0001);
      op_valid = 1'b0;
      @(negedge clk);
      check("R1 b2b drop done", {3'b0, res_done}, 4'b0);

      // R9: reset mid-stream clears outputs
      issue(1'b0, 1'b1, ONE, ONE);
      @(negedge clk);
      op_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R9 async clear cc", res_cc, 4'b0000);
      check("R9 async clear invalid", {3'b0, res_invalid}, 4'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 post clear done", {3'b0, res_done}, 4'b0);

      finish_run();
   end

endmodule